// File: doc/BRIEF.md
# Register-List Stack Transfer Sequencer

This block performs multi-register save and restore operations against one of two 16-bit stack pointers, a system pointer and a user pointer. The caller supplies an 8-bit selection mask, a direction (save or restore), a stack choice and a one-cycle start strobe. Together with the strobe it presents the current contents of the full register set. The sequencer then moves every selected register through a byte-wide memory port, one byte per clock. The slot order is fixed by hardware and cannot be changed by the caller.

On a save, the active pointer is decremented before every byte is written. Each 16-bit register goes out low byte first, so it ends up big-endian in memory. On a restore, each byte is read at the pointer and the pointer is then incremented. The restore order is the exact reverse of the save order. When the work is finished, the block raises a one-cycle done pulse. At the same time it presents the updated register set, both stack pointers and the number of memory cycles it used. If the program counter was restored, it also flags a redirect so the fetch logic can reload.

Top module: `regstack_seq`

## Requirements
- R1: A save writes the selected slots from mask bit 7 down to mask bit 0. The slots are 7 program counter, 6 opposite stack pointer, 5 Y, 4 X, 3 page register, 2 B, 1 A, 0 flags. Each selected slot is transferred exactly once.
- R2: A restore reads the selected slots from mask bit 0 up to mask bit 7, which is the exact reverse of the save order.
- R3: Slots 7 to 4 are 16 bits wide. A save writes the low byte and then the high byte. A restore reads the high byte at the lower address and then the low byte.
- R4: A save decrements the active pointer before each byte write. A restore reads at the pointer and then increments it. The final pointer differs from the starting value by the byte count.
- R5: Slot 6 carries the user pointer when the system stack is active (`use_user`=0), and the system pointer when the user stack is active (`use_user`=1).
- R6: Selecting both A (bit 1) and B (bit 2) stores them as one big-endian 16-bit value, with A at the lower address.
- R7: An all-zero mask raises done on the next cycle. It makes no memory access and leaves both pointers unchanged.
- R8: Exactly one memory access occurs per clock while transferring. At done, `cyc_count` equals the bytes moved (2 per wide slot, 1 per narrow slot).
- R9: Done is a single-cycle pulse that follows the last transfer cycle directly. A start strobe that arrives while an operation is in progress is ignored.
- R10: `branch_taken` is high together with done only when a restore included the program counter (bit 7).
- R11: At done, registers that were not restored hold their start values, and restored registers hold the bytes read from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| pull | input | 1 | 1 = restore from stack, 0 = save to stack |
| use_user | input | 1 | 1 = user stack active, 0 = system stack active |
| sel_mask | input | 8 | Slot selection mask |
| pc_in | input | 16 | Program counter at start |
| s_in | input | 16 | System stack pointer at start |
| u_in | input | 16 | User stack pointer at start |
| y_in | input | 16 | Y index at start |
| x_in | input | 16 | X index at start |
| dp_in | input | 8 | Page register at start |
| b_in | input | 8 | Accumulator B at start |
| a_in | input | 8 | Accumulator A at start |
| cc_in | input | 8 | Flags at start |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the cycle of mem_re |
| done | output | 1 | Operation finished (one cycle) |
| branch_taken | output | 1 | Program counter was restored |
| cyc_count | output | 5 | Memory cycles used by the operation |
| pc_out | output | 16 | Resulting program counter |
| s_out | output | 16 | Resulting system stack pointer |
| u_out | output | 16 | Resulting user stack pointer |
| y_out | output | 16 | Resulting Y |
| x_out | output | 16 | Resulting X |
| dp_out | output | 8 | Resulting page register |
| b_out | output | 8 | Resulting B |
| a_out | output | 8 | Resulting A |
| cc_out | output | 8 | Resulting flags |

## Verification
The start strobe is captured on one clock edge. The first memory access is visible in the following cycle, and one byte moves on each later edge. Done and the result registers therefore appear exactly n+1 cycles after the start edge for n bytes, and one cycle after it for an empty mask. The bench drives and samples on falling edges. It counts those edges from the strobe and checks that done arrives on edge n+1. It logs every access on the cycle where it appears and compares that sequence, along with the registers, count and redirect flag, with a reference model evaluated at the done cycle.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int NSLOT = 8;
  localparam int NHALF = NSLOT / 2;
  localparam int SLOT_W = $clog2(NSLOT);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } rsq_state_e;
endpackage

// File: rtl/rsq_slot_pick.sv
module rsq_slot_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic          top_first,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] hi_idx;
  logic [IW-1:0] lo_idx;

  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i]) hi_idx = IW'(i);
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) lo_idx = IW'(i);
    end
  end

  assign idx = top_first ? hi_idx : lo_idx;
endmodule

// File: rtl/rsq_byte_src.sv
module rsq_byte_src #(
  parameter int DW = 8,
  parameter int NW = 4,
  localparam int WIW = $clog2(NW)
) (
  input  logic [NW-1:0][2*DW-1:0] wide_regs,
  input  logic [NW-1:0][DW-1:0]   narrow_regs,
  input  logic                    is_wide,
  input  logic [WIW-1:0]          sub_idx,
  input  logic                    hi_sel,
  output logic [DW-1:0]           byte_o
);
  logic [2*DW-1:0] wsel;
  assign wsel = wide_regs[sub_idx];

  always_comb begin
    if (is_wide) byte_o = hi_sel ? wsel[2*DW-1:DW] : wsel[DW-1:0];
    else         byte_o = narrow_regs[sub_idx];
  end
endmodule

// File: rtl/regstack_seq.sv
module regstack_seq
  import rsq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          pull,
  input  logic          use_user,
  input  logic [7:0]    sel_mask,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] s_in,
  input  logic [AW-1:0] u_in,
  input  logic [AW-1:0] y_in,
  input  logic [AW-1:0] x_in,
  input  logic [DW-1:0] dp_in,
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] cc_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          branch_taken,
  output logic [CW-1:0] cyc_count,
  output logic [AW-1:0] pc_out,
  output logic [AW-1:0] s_out,
  output logic [AW-1:0] u_out,
  output logic [AW-1:0] y_out,
  output logic [AW-1:0] x_out,
  output logic [DW-1:0] dp_out,
  output logic [DW-1:0] b_out,
  output logic [DW-1:0] a_out,
  output logic [DW-1:0] cc_out
);
  localparam int WIW = $clog2(NHALF);

  rsq_state_e st_q;
  logic [NSLOT-1:0]           pend_q;
  logic                       phase_q;
  logic                       pull_q;
  logic                       user_q;
  logic                       pcpull_q;
  logic [AW-1:0]              sp_q;
  logic [CW-1:0]              cnt_q;
  logic [NHALF-1:0][2*DW-1:0] wide_q;
  logic [NHALF-1:0][DW-1:0]   nar_q;

  logic [SLOT_W-1:0] cur_idx;
  logic              cur_wide;
  logic              hi_sel;
  logic              last_byte;
  logic [NSLOT-1:0]  pend_nxt;
  logic [DW-1:0]     out_byte;

  rsq_slot_pick #(.N(NSLOT)) u_pick (
    .pend      (pend_q),
    .top_first (~pull_q),
    .idx       (cur_idx)
  );

  assign cur_wide  = cur_idx[SLOT_W-1];
  assign hi_sel    = phase_q ^ pull_q;
  assign last_byte = ~cur_wide | phase_q;
  assign pend_nxt  = pend_q & ~(NSLOT'(1) << cur_idx);

  rsq_byte_src #(.DW(DW), .NW(NHALF)) u_src (
    .wide_regs   (wide_q),
    .narrow_regs (nar_q),
    .is_wide     (cur_wide),
    .sub_idx     (cur_idx[WIW-1:0]),
    .hi_sel      (hi_sel),
    .byte_o      (out_byte)
  );

  assign mem_we    = (st_q == ST_XFER) & ~pull_q;
  assign mem_re    = (st_q == ST_XFER) & pull_q;
  assign mem_addr  = pull_q ? sp_q : sp_q - AW'(1);
  assign mem_wdata = out_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      pend_q   <= '0;
      phase_q  <= 1'b0;
      pull_q   <= 1'b0;
      user_q   <= 1'b0;
      pcpull_q <= 1'b0;
      sp_q     <= '0;
      cnt_q    <= '0;
      wide_q   <= '0;
      nar_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            wide_q[3] <= pc_in;
            wide_q[2] <= use_user ? s_in : u_in;
            wide_q[1] <= y_in;
            wide_q[0] <= x_in;
            nar_q[3]  <= dp_in;
            nar_q[2]  <= b_in;
            nar_q[1]  <= a_in;
            nar_q[0]  <= cc_in;
            sp_q      <= use_user ? u_in : s_in;
            pend_q    <= sel_mask;
            phase_q   <= 1'b0;
            cnt_q     <= '0;
            pull_q    <= pull;
            user_q    <= use_user;
            pcpull_q  <= pull & sel_mask[NSLOT-1];
            st_q      <= (sel_mask == '0) ? ST_FIN : ST_XFER;
          end
        end
        ST_XFER: begin
          sp_q  <= pull_q ? sp_q + AW'(1) : sp_q - AW'(1);
          cnt_q <= cnt_q + CW'(1);
          if (pull_q) begin
            if (cur_wide) begin
              if (hi_sel) wide_q[cur_idx[WIW-1:0]][2*DW-1:DW] <= mem_rdata;
              else        wide_q[cur_idx[WIW-1:0]][DW-1:0]    <= mem_rdata;
            end else begin
              nar_q[cur_idx[WIW-1:0]] <= mem_rdata;
            end
          end
          if (last_byte) begin
            pend_q  <= pend_nxt;
            phase_q <= 1'b0;
            if (pend_nxt == '0) st_q <= ST_FIN;
          end else begin
            phase_q <= 1'b1;
          end
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done         = (st_q == ST_FIN);
  assign branch_taken = (st_q == ST_FIN) & pcpull_q;
  assign cyc_count    = cnt_q;
  assign pc_out       = wide_q[3];
  assign y_out        = wide_q[1];
  assign x_out        = wide_q[0];
  assign s_out        = user_q ? wide_q[2] : sp_q;
  assign u_out        = user_q ? sp_q : wide_q[2];
  assign dp_out       = nar_q[3];
  assign b_out        = nar_q[2];
  assign a_out        = nar_q[1];
  assign cc_out       = nar_q[0];
endmodule

// File: rtl/regstack_seq_chk.sv
module regstack_seq_chk #(
  parameter int AW = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          idle,
  input logic [7:0]    sel_mask,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          mem_re,
  input logic          done,
  input logic          branch_taken,
  input logic [CW-1:0] cyc_count
);
  logic [CW-1:0] acc_cnt;

  always_ff @(posedge clk) begin
    if (rst) acc_cnt <= '0;
    else if (start && idle) acc_cnt <= '0;
    else if (mem_we || mem_re) acc_cnt <= acc_cnt + CW'(1);
  end

  assert_push_descends_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - AW'(1)));

  assert_pull_ascends_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  assert_empty_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (start && idle && sel_mask == 8'h00) |=> (done && !mem_we && !mem_re));

  assert_count_matches_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (cyc_count == acc_cnt));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_quiet_at_done_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mem_we && !mem_re));

  assert_redirect_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    branch_taken |-> done);
endmodule

bind regstack_seq regstack_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .idle         (st_q == rsq_pkg::ST_IDLE),
  .sel_mask     (sel_mask),
  .mem_addr     (mem_addr),
  .mem_we       (mem_we),
  .mem_re       (mem_re),
  .done         (done),
  .branch_taken (branch_taken),
  .cyc_count    (cyc_count)
);

// File: tb/regstack_seq_tb.sv
module regstack_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, pull = 1'b0, use_user = 1'b0;
  logic [7:0]  sel_mask = '0;
  logic [15:0] pc_i = '0, s_i = '0, u_i = '0, y_i = '0, x_i = '0;
  logic [7:0]  dp_i = '0, b_i = '0, a_i = '0, cc_i = '0;
  logic [15:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        done, branch_taken;
  logic [4:0]  cyc_count;
  logic [15:0] pc_o, s_o, u_o, y_o, x_o;
  logic [7:0]  dp_o, b_o, a_o, cc_o;

  logic [7:0] mem [256];
  int n_run = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;
  assign mem_rdata = mem[mem_addr[7:0]];

  regstack_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .pull(pull), .use_user(use_user),
    .sel_mask(sel_mask), .pc_in(pc_i), .s_in(s_i), .u_in(u_i), .y_in(y_i),
    .x_in(x_i), .dp_in(dp_i), .b_in(b_i), .a_in(a_i), .cc_in(cc_i),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
    .branch_taken(branch_taken), .cyc_count(cyc_count),
    .pc_out(pc_o), .s_out(s_o), .u_out(u_o), .y_out(y_o), .x_out(x_o),
    .dp_out(dp_o), .b_out(b_o), .a_out(a_o), .cc_out(cc_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      finish_run();
    end
  end

  function automatic logic is_wide(input int s);
    return s >= 4;
  endfunction

  // one operation: model, drive, observe, compare
  task automatic run_op(input logic p, input logic uu, input logic [7:0] m, input bit poke);
    logic [15:0] w [4];
    logic [7:0]  nb [4];
    logic [15:0] sp, ea [12];
    logic [7:0]  ed [12];
    logic [15:0] ga [12];
    logic [7:0]  gd [12];
    logic        gw [12];
    int n = 0, k = 0, nacc = 0;
    bit got = 0;
    string ordr = p ? "R2" : "R1";
    logic [15:0] es, eu;
    w[3] = pc_i; w[2] = uu ? s_i : u_i; w[1] = y_i; w[0] = x_i;
    nb[3] = dp_i; nb[2] = b_i; nb[1] = a_i; nb[0] = cc_i;
    sp = uu ? u_i : s_i;
    if (!p) begin
      for (int s = 7; s >= 0; s--) if (m[s]) begin
        if (is_wide(s)) begin
          sp--; ea[n] = sp; ed[n] = w[s-4][7:0]; n++;
          sp--; ea[n] = sp; ed[n] = w[s-4][15:8]; n++;
        end else begin
          sp--; ea[n] = sp; ed[n] = nb[s]; n++;
        end
      end
    end else begin
      for (int s = 0; s < 8; s++) if (m[s]) begin
        if (is_wide(s)) begin
          ea[n] = sp; ed[n] = mem[sp[7:0]]; w[s-4][15:8] = mem[sp[7:0]]; n++; sp++;
          ea[n] = sp; ed[n] = mem[sp[7:0]]; w[s-4][7:0] = mem[sp[7:0]]; n++; sp++;
        end else begin
          ea[n] = sp; ed[n] = mem[sp[7:0]]; nb[s] = mem[sp[7:0]]; n++; sp++;
        end
      end
    end
    es = uu ? w[2] : sp;
    eu = uu ? sp : w[2];

    pull = p; use_user = uu; sel_mask = m; start = 1'b1;
    while (!got && k < 40) begin
      @(negedge clk); k++;
      if (k == 1) start = 1'b0;
      if (poke && k == 2) begin start = 1'b1; sel_mask = ~m; pull = ~p; end
      if (poke && k == 3) start = 1'b0;
      if (mem_we || mem_re) begin
        if (nacc < 12) begin
          ga[nacc] = mem_addr; gw[nacc] = mem_we;
          gd[nacc] = mem_we ? mem_wdata : mem_rdata;
        end
        if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
        nacc++;
      end
      if (done) got = 1;
    end
    chk(got && k == n + 1, "R9", "done cycle after start", k, n + 1);
    chk(nacc == n, "R8", "access count", nacc, n);
    chk(cyc_count == 5'(n), "R8", "cyc_count", cyc_count, n);
    for (int i = 0; i < n && i < nacc && i < 12; i++) begin
      chk(gw[i] == !p, ordr, "access direction", gw[i], !p);
      chk(ga[i] == ea[i], "R4", "access address", ga[i], ea[i]);
      chk(gd[i] == ed[i], (m[7:4] != 0) ? "R3" : ordr, "access byte", gd[i], ed[i]);
    end
    chk(s_o == es, "R5", "s_out", s_o, es);
    chk(u_o == eu, "R5", "u_out", u_o, eu);
    chk({pc_o, y_o, x_o} == {w[3], w[1], w[0]}, "R11", "wide regs",
        32'({pc_o, y_o} ^ {w[3], w[1]}), 0);
    chk(x_o == w[0], "R11", "x_out", x_o, w[0]);
    chk({dp_o, b_o, a_o, cc_o} == {nb[3], nb[2], nb[1], nb[0]}, "R11", "byte regs",
        {dp_o, b_o, a_o, cc_o}, {nb[3], nb[2], nb[1], nb[0]});
    chk(branch_taken == (p & m[7]), "R10", "branch_taken", branch_taken, p & m[7]);
    @(negedge clk);
    chk(!done, "R9", "done single pulse", done, 0);
    start = 1'b0;
  endtask

  task automatic rand_regs();
    pc_i = 16'($urandom); y_i = 16'($urandom); x_i = 16'($urandom);
    s_i = {8'($urandom), 8'(8'h30 + $urandom_range(0, 160))};
    u_i = {8'($urandom), 8'(8'h30 + $urandom_range(0, 160))};
    dp_i = 8'($urandom); b_i = 8'($urandom); a_i = 8'($urandom); cc_i = 8'($urandom);
  endtask

  initial begin
    logic [15:0] sp0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !mem_we && !mem_re && cyc_count == 0, "R9", "reset state",
        {done, mem_we, mem_re, cyc_count}, 0);

    // R7: empty masks
    rand_regs(); run_op(1'b0, 1'b0, 8'h00, 0);
    rand_regs(); run_op(1'b1, 1'b1, 8'h00, 0);

    // R6: A and B as a big-endian pair, A at lower address
    rand_regs(); sp0 = s_i;
    run_op(1'b0, 1'b0, 8'h06, 0);
    chk(mem[8'(sp0[7:0] - 8'd2)] == a_i, "R6", "A at lower address",
        mem[8'(sp0[7:0] - 8'd2)], a_i);
    chk(mem[8'(sp0[7:0] - 8'd1)] == b_i, "R6", "B at higher address",
        mem[8'(sp0[7:0] - 8'd1)], b_i);

    // R5 and R9: full save on user stack, with a start poke while busy
    rand_regs(); run_op(1'b0, 1'b1, 8'hFF, 1);
    // R10: full restore from the same place, including the program counter
    u_i = u_i - 16'd12; run_op(1'b1, 1'b1, 8'hFF, 0);
    // R5: slot 6 on the system stack holds the user pointer
    rand_regs(); run_op(1'b0, 1'b0, 8'h40, 0);
    rand_regs(); run_op(1'b1, 1'b0, 8'h40, 0);

    for (int t = 0; t < 60; t++) begin
      rand_regs();
      run_op(1'($urandom), 1'($urandom), 8'($urandom), 0);
    end
    finish_run();
  end
endmodule